// File: doc/BRIEF.md
# Counterflow Systolic FIR Convolver

The block computes a one-dimensional FIR convolution on a linear chain of K multiply-accumulate cells. Each cell keeps one coefficient for the whole run. Samples travel through the chain from the input end toward the far end. Partial sums travel the other way: they start as zero at the far end and grow by one product in each cell they pass. A finished result leaves at the input end of the chain, on the side opposite to where the partial sums start.

For the two opposite streams to line up, every real sample must be followed by a zero slot. The block adds these slots itself. After each accepted sample it spends one cycle clocking a zero into the chain, so a sample can be accepted at most every second cycle. Sum and sample slots therefore alternate along the chain. A result slot meets each sample of its window in exactly one cell, and it meets only zeros in between.

Both data edges are valid/ready streams. A sample moves on a cycle where `in_valid` and `in_ready` are both high. A result moves on a cycle where `out_valid` and `out_ready` are both high. While a result is waiting, the whole chain stops and `in_ready` stays low until the result is taken. The coefficient write port is a plain write strobe with an index. It is meant for use between streams. Writes are not blocked during streaming, and their timing is defined by R8.

Top module: `cflow_fir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and all K coefficients are zero, so a stream sent without any coefficient write yields only zero results.
- R2: A cycle with `coef_we` high stores `coef_data` into coefficient number `coef_idx`, for indices 0 to K-1. Coefficient k multiplies the sample k positions after the first sample of a window. A write with an index of K or more changes nothing.
- R3: Samples are numbered from 1 after reset, with x_n being the n-th accepted sample. Result number j is c0*x_j + c1*x_(j+1) + ... + c(K-1)*x_(j+K-1). The first K-1 samples produce no result. Sample n, for n >= K, produces result n-K+1. Results come out in increasing j.
- R4: In the cycle after a sample is accepted, `in_ready` is 0; this is the zero slot. If no result is being held, `in_ready` returns to 1 in the cycle after that.
- R5: In the cycle after sample n is accepted, with n >= K, `out_valid` is 1 and `out_data` carries result n-K+1. After the first K-1 samples, `out_valid` stays 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_data` unchanged, and no sample is accepted.
- R7: `out_data` is a signed value 2*DW + ceil(log2 K) bits wide. Every result is exact, including those built from the most negative sample and coefficient values.
- R8: A coefficient write takes effect from the next chain step. If coefficient K-1 is written in the same cycle that sample n is accepted, result n-K+1 still uses the old value, and every later result uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | max(1, ceil(log2 K)) | Coefficient index to write |
| coef_data | input | DW | Signed coefficient value |
| in_valid | input | 1 | Sample available |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | DW | Signed sample |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_data | output | 2*DW + ceil(log2 K) | Signed result |

## Verification
Two events can land in the same cycle: a coefficient write and the acceptance of a sample. The bench provokes this by raising `coef_we` for coefficient K-1 on the very cycle a mid-stream sample's handshake completes. It then judges the result stream against an arithmetic model in which the switch point falls exactly between results n-K+1 and n-K+2. The hold of a waiting result is also exercised: the consumer's readiness is driven from a pseudo-random sequence, so back-pressure coincides with zero-slot cycles and with sample arrivals.

// File: rtl/cflow_pkg.sv
package cflow_pkg;

  // Chain phase: a sample slot alternates with a zero slot
  typedef enum logic {
    PH_SAMPLE = 1'b0,
    PH_GAP    = 1'b1
  } phase_e;

  // Result width: full product plus growth from summing K products
  function automatic int acc_width(input int dw, input int k);
    return 2 * dw + $clog2(k);
  endfunction

endpackage

// File: rtl/cflow_ctl.sv
module cflow_ctl #(
  parameter int K = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic take,
  output logic step
);
  import cflow_pkg::*;

  localparam int FW = $clog2(K + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(K - 1);

  phase_e          phase_q;
  logic [FW-1:0]   fill_q;
  logic            ov_q;
  logic            gap_step;

  assign in_ready  = (phase_q == PH_SAMPLE);
  assign take      = in_ready && in_valid;
  assign gap_step  = (phase_q == PH_GAP) && (!ov_q || out_ready);
  assign step      = take || gap_step;
  assign out_valid = ov_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_SAMPLE;
      fill_q  <= '0;
      ov_q    <= 1'b0;
    end else if (take) begin
      phase_q <= PH_GAP;
      ov_q    <= (fill_q == FILL_MAX);
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end else if (gap_step) begin
      phase_q <= PH_SAMPLE;
      ov_q    <= 1'b0;
    end
  end

endmodule

// File: rtl/cflow_coef_bank.sv
module cflow_coef_bank #(
  parameter int DW = 8,
  parameter int K  = 3,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        idx,
  input  logic signed [DW-1:0] data,
  output logic signed [DW-1:0] coef [K]
);

  logic signed [DW-1:0] coef_q [K];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < K; k++) coef_q[k] <= '0;
    end else if (we) begin
      for (int k = 0; k < K; k++)
        if (idx == IW'(k)) coef_q[k] <= data;
    end
  end

  assign coef = coef_q;

endmodule

// File: rtl/cflow_cell.sv
module cflow_cell #(
  parameter int DW = 8,
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [DW-1:0] w,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [AW-1:0] y_in,
  output logic signed [DW-1:0] x_out,
  output logic signed [AW-1:0] y_out
);

  logic signed [AW-1:0] prod;
  logic signed [DW-1:0] x_q;
  logic signed [AW-1:0] y_q;

  assign prod = AW'(w) * AW'(x_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      x_q <= x_in;
      y_q <= y_in + prod;
    end
  end

  assign x_out = x_q;
  assign y_out = y_q;

endmodule

// File: rtl/cflow_fir.sv
module cflow_fir #(
  parameter  int DW = 8,
  parameter  int K  = 3,
  localparam int AW = cflow_pkg::acc_width(DW, K),
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_we,
  input  logic [IW-1:0]        coef_idx,
  input  logic signed [DW-1:0] coef_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [AW-1:0] out_data
);

  logic                 take;
  logic                 step;
  logic signed [DW-1:0] coef   [K];
  logic signed [DW-1:0] x_link [K+1];
  logic signed [AW-1:0] y_link [K+1];
  logic                 unused_x_tail;

  cflow_ctl #(.K(K)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .take      (take),
    .step      (step)
  );

  cflow_coef_bank #(.DW(DW), .K(K), .IW(IW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_we),
    .idx   (coef_idx),
    .data  (coef_data),
    .coef  (coef)
  );

  // The zero slot enters whenever the chain steps without a sample
  assign x_link[0] = take ? in_data : '0;
  assign y_link[K] = '0;

  // Cell p holds coefficient K-1-p: the far cell meets a sum first,
  // pairing it with the oldest sample of its window
  for (genvar p = 0; p < K; p++) begin : g_cell
    cflow_cell #(.DW(DW), .AW(AW)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .w     (coef[K-1-p]),
      .x_in  (x_link[p]),
      .y_in  (y_link[p+1]),
      .x_out (x_link[p+1]),
      .y_out (y_link[p])
    );
  end

  assign unused_x_tail = ^x_link[K];
  assign out_data      = y_link[0];

endmodule

// File: rtl/cflow_fir_chk.sv
module cflow_fir_chk #(
  parameter int DW = 8,
  parameter int K  = 3
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          in_valid,
  input logic                                          in_ready,
  input logic                                          out_valid,
  input logic                                          out_ready,
  input logic signed [cflow_pkg::acc_width(DW,K)-1:0]  out_data
);

  // R4: the cycle after an accepted sample is a zero slot
  a_r4_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4: the zero slot ends as soon as no result is held
  a_r4_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !(out_valid && !out_ready)) |=> in_ready);

  // R6: a refused result is held unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: no sample is taken while a result is presented
  a_r6_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R5: a result only appears right after a sample handshake
  a_r5_result_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

bind cflow_fir cflow_fir_chk #(.DW(DW), .K(K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/cflow_fir_tb.sv
module cflow_fir_tb;

  localparam int DW = 8;
  localparam int K  = 3;
  localparam int AW = cflow_pkg::acc_width(DW, K);
  localparam int IW = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 coef_we = 1'b0;
  logic [IW-1:0]        coef_idx = '0;
  logic signed [DW-1:0] coef_data = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic signed [AW-1:0] out_data;

  cflow_fir #(.DW(DW), .K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #5 clk = ~clk;

  int    checks = 0, fails = 0, cyc = 0;
  int    xs [0:511];
  int    c_old [K], c_new [K];
  int    sw, nsent, nres;
  bit    bp_mode = 1'b0;
  string cur_tag = "R3";
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_hold = 1'b0;
  logic signed [AW-1:0] prev_data = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expv(input int j);
    longint s = 0;
    for (int k = 0; k < K; k++)
      s += longint'((j >= sw) ? c_new[k] : c_old[k]) * longint'(xs[j+k]);
    return s;
  endfunction

  // Consumer: choose readiness, then judge what the next edge will take
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_hold = 1'b0;
    end else begin
      if (prev_hold)
        chk(out_valid && (out_data == prev_data), "R6 held result",
            longint'($signed(out_data)), longint'($signed(prev_data)));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_mode ? lfsr[0] : 1'b1;
      if (out_valid && out_ready) begin
        nres++;
        chk(out_data == AW'(expv(nres)), cur_tag,
            longint'($signed(out_data)), expv(nres));
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; coef_we = 1'b0; bp_mode = 1'b0;
    repeat (3) @(negedge clk);
    nsent = 0; nres = 0; sw = 1 << 30;
    for (int k = 0; k < K; k++) begin c_old[k] = 0; c_new[k] = 0; end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_coef(input int idx, input int val);
    coef_we = 1'b1; coef_idx = IW'(idx); coef_data = DW'(val);
    @(negedge clk);
    coef_we = 1'b0;
    if (idx < K) begin c_old[idx] = val; c_new[idx] = val; end
  endtask

  // Called at a falling edge; optionally writes coefficient K-1 in the handshake cycle
  task automatic send(input int x, input bit wr = 1'b0, input int wval = 0);
    in_data = DW'(x); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    xs[nsent + 1] = x;
    if (wr) begin
      coef_we = 1'b1; coef_idx = IW'(K - 1); coef_data = DW'(wval);
      c_new[K-1] = wval; sw = nsent + 1 - K + 2;
    end
    @(negedge clk);
    in_valid = 1'b0; coef_we = 1'b0;
    nsent++;
    chk(!in_ready, "R4 zero slot", longint'(in_ready), 0);
    if (nsent >= K) chk(out_valid, "R5 result valid", longint'(out_valid), 1);
    else            chk(!out_valid, "R3 warm-up", longint'(out_valid), 0);
    if (!bp_mode) begin
      @(negedge clk);
      chk(in_ready, "R4 reopen", longint'(in_ready), 1);
    end
  endtask

  task automatic drain(input string tag);
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    chk(nres == ((nsent >= K) ? nsent - K + 1 : 0), tag, nres, nsent - K + 1);
  endtask

  task automatic run_set(input int c0, input int c1, input int c2,
                         input int pat, input int n, input string tag);
    do_reset();
    cur_tag = tag;
    write_coef(0, c0); write_coef(1, c1); write_coef(2, c2);
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: send(i - 5);
        1: send((i % 2 == 0) ? -128 : 127);
        2: send(((i * 37 + 11) % 256) - 128);
        3: send(-128);
        default: send(127);
      endcase
    end
    drain({tag, " count"});
  endtask

  initial begin
    do_reset();
    chk(in_ready, "R1 ready after reset", longint'(in_ready), 1);
    chk(!out_valid, "R1 no result after reset", longint'(out_valid), 0);

    // R1: zero coefficients after reset
    cur_tag = "R1 zero coefficients";
    for (int i = 0; i < 6; i++) send(i * 17 - 40);
    drain("R1 count");

    // R2: coefficient placement within the window
    run_set(1, 0, 0, 2, 8, "R2 first tap");
    run_set(0, 0, 1, 2, 8, "R2 last tap");
    run_set(1, 2, 3, 0, 12, "R3 ramp");
    run_set(-128, 127, -1, 1, 12, "R3 alternating");

    // R7: extremes of the result range
    run_set(-128, -128, -128, 3, 6, "R7 max positive");
    run_set(127, 127, 127, 3, 6, "R7 max negative");
    run_set(127, -128, 127, 1, 8, "R7 mixed extremes");

    // R2: out-of-range index leaves every coefficient alone
    do_reset();
    cur_tag = "R2 index ignored";
    write_coef(0, 1); write_coef(1, 1); write_coef(2, 1);
    write_coef(3, 99);
    for (int i = 0; i < 8; i++) send(i * 9 - 30);
    drain("R2 count");

    // R3: sweep every sample value
    run_set(3, -5, 7, 2, 0, "R3 sweep");
    cur_tag = "R3 sweep";
    for (int v = -128; v < 128; v++) send(v);
    drain("R3 sweep count");

    // R6: pseudo-random back-pressure
    do_reset();
    cur_tag = "R6 back-pressure";
    write_coef(0, 5); write_coef(1, -7); write_coef(2, 3);
    bp_mode = 1'b1;
    for (int i = 0; i < 40; i++) send(((i * 53 + 7) % 256) - 128);
    drain("R6 count");

    // R8: coefficient write in the same cycle as a sample handshake
    do_reset();
    cur_tag = "R8 write with sample";
    write_coef(0, 2); write_coef(1, -3); write_coef(2, 4);
    for (int i = 1; i <= 9; i++) begin
      if (i == 5) send(i * 11 - 20, 1'b1, 9);
      else        send(i * 11 - 20);
    end
    drain("R8 count");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule